// File: doc/BRIEF.md
# Page Request Event Notifier

This block holds the status and event-control state that decides when a page-request notification interrupt goes out. A queue writer elsewhere in the translation unit pulses set strobes when it appends a request (pending) or finds the queue full (overflow). After each such update it raises an event request that carries the two status bits as they stood before the update. The block accepts an event only if neither bit was already set. It then either fires an interrupt or, while software has the interrupt masked, records it as interrupt-pending so that it is sent on unmask.

Software reaches four registers through one write port. They are the two-bit status register with write-1-to-clear bits, the control register holding the mask and a read-only pending flag, and the message data and message address registers. The interrupt request is a one-cycle pulse. The programmed address and data sit on their own outputs for the delivery logic to fetch when the pulse arrives. Message delivery is outside this block.

Top module: `prq_notify`

## Requirements
- R1: After reset, status is 0, the mask (control bit 31) is 1, interrupt-pending (control bit 30) is 0, message data and address are 0, and irq_o is low.
- R2: Status bit 0 (pending request) is set by set_pend_i and bit 1 (overflow) by set_ovf_i. A register write with reg_sel_i=0 clears each bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R3: When a set strobe and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: An event request whose captured previous status has bit 0 or bit 1 set is ignored: no interrupt and no change to interrupt-pending.
- R5: An accepted event (captured status 0) while the mask is 0 raises irq_o for exactly one cycle, starting the cycle after the request, and leaves interrupt-pending at 0.
- R6: An accepted event while the mask is 1 sets interrupt-pending and raises no interrupt.
- R7: A control write (reg_sel_i=1) with bit 31 = 0 while interrupt-pending is 1 clears interrupt-pending and raises irq_o for one cycle, starting the next cycle.
- R8: A status write after which both status bits are 0 clears interrupt-pending without an interrupt. A later unmask then fires nothing.
- R9: In the control register only bit 31 is writable. Bit 30 ignores software writes, and all other bits read 0.
- R10: Message data (reg_sel_i=2) keeps write bits 15:0 and reads 0 above them. Message address (reg_sel_i=3) keeps write bits 31:2 and reads 0 in bits 1:0. Both outputs present the programmed values while irq_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 control, 2 message data, 3 message address |
| reg_wdata_i | input | 32 | Register write data |
| set_pend_i | input | 1 | Hardware set of the pending-request status bit |
| set_ovf_i | input | 1 | Hardware set of the overflow status bit |
| evt_req_i | input | 1 | Event request from the queue writer |
| evt_prev_sts_i | input | 2 | Status bits as seen before the update that raised the event |
| status_o | output | 32 | Status register view |
| ctrl_o | output | 32 | Control register view |
| irq_o | output | 1 | One-cycle interrupt request |
| msg_addr_o | output | 32 | Programmed message address |
| msg_data_o | output | 32 | Programmed message data |

## Verification
Directed sequences separate events that are accepted from events that are suppressed by either captured status bit. They also separate masked events, which must be replayed on unmask, from unmasked ones that fire at once, and a replay from one dropped by a status clear. A collision of a hardware set with a write-1-to-clear shows which side wins. Random traffic then mixes writes to every register with set strobes and events whose captured status is zero about half the time. This brings up overlaps the directed cases miss: an event in the same cycle as an unmask or a status clear, and writes that try to set the read-only pending flag.

// File: rtl/prq_evt_pkg.sv
`timescale 1ns/1ps
package prq_evt_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned STS_W        = 2;
  localparam int unsigned STS_PEND_BIT = 0;
  localparam int unsigned STS_OVF_BIT  = 1;
  localparam int unsigned CTL_MASK_BIT = 31;
  localparam int unsigned CTL_IP_BIT   = 30;

  typedef enum logic [1:0] {
    SEL_STS  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_ADDR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prq_status_reg.sv
`timescale 1ns/1ps
module prq_status_reg
  import prq_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [STS_W-1:0] w1c_i,
  input  logic             set_pend_i,
  input  logic             set_ovf_i,
  output logic [STS_W-1:0] sts_o,
  output logic             wr_all_clear_o
);
  logic [STS_W-1:0] sts_q, sts_d, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[STS_PEND_BIT] = set_pend_i;
    set_vec[STS_OVF_BIT]  = set_ovf_i;
    clr_vec = wr_i ? w1c_i : '0;
    // hardware set wins over a software clear
    sts_d = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o          = sts_q;
  assign wr_all_clear_o = wr_i && (sts_d == '0);

  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && w1c_i[STS_PEND_BIT] && !set_pend_i) |=> !sts_o[STS_PEND_BIT]);
  a_r3_set_wins_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pend_i |=> sts_o[STS_PEND_BIT]);
  a_r3_set_wins_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ovf_i |=> sts_o[STS_OVF_BIT]);
endmodule

// File: rtl/prq_event_ctl.sv
`timescale 1ns/1ps
module prq_event_ctl
  import prq_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             mask_wdata_i,
  input  logic             sts_clear_i,
  input  logic             evt_req_i,
  input  logic [STS_W-1:0] evt_prev_i,
  output logic             mask_o,
  output logic             ip_o,
  output logic             irq_o
);
  logic mask_q, ip_q, irq_q;
  logic accept, ip_mid, unmask_fire, fire, ip_d, mask_d;

  always_comb begin
    accept      = evt_req_i && (evt_prev_i == '0);
    // status clear first, then a fresh event may set pending again
    ip_mid      = sts_clear_i ? 1'b0 : ip_q;
    if (accept && mask_q) ip_mid = 1'b1;
    mask_d      = ctl_wr_i ? mask_wdata_i : mask_q;
    unmask_fire = ctl_wr_i && !mask_wdata_i && ip_mid;
    fire        = (accept && !mask_q) || unmask_fire;
    ip_d        = unmask_fire ? 1'b0 : ip_mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      ip_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ip_q   <= ip_d;
      irq_q  <= fire;
    end
  end

  assign mask_o = mask_q;
  assign ip_o   = ip_q;
  assign irq_o  = irq_q;

  a_r4_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_req_i && (evt_prev_i != '0) && !ctl_wr_i) |=> !irq_o);
  a_r6_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !ctl_wr_i) |=> !irq_o);
  a_r7_unmask_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !mask_wdata_i && ip_q) |=> (irq_o && !ip_o));
  a_r5_no_ip_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_o |-> !ip_o);
endmodule

// File: rtl/prq_msg_regs.sv
`timescale 1ns/1ps
module prq_msg_regs #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_wr_i,
  input  logic             addr_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] data_o,
  output logic [REG_W-1:0] addr_o
);
  localparam int unsigned ADDR_W = REG_W - ADDR_LSB;

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (data_wr_i) data_q <= wdata_i[DATA_W-1:0];
      if (addr_wr_i) addr_q <= wdata_i[REG_W-1:ADDR_LSB];
    end
  end

  generate
    if (DATA_W < REG_W) begin : g_data_pad
      assign data_o = {{(REG_W-DATA_W){1'b0}}, data_q};
    end else begin : g_data_full
      assign data_o = data_q;
    end
  endgenerate

  assign addr_o = {addr_q, {ADDR_LSB{1'b0}}};
endmodule

// File: rtl/prq_notify.sv
`timescale 1ns/1ps
module prq_notify
  import prq_evt_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             set_pend_i,
  input  logic             set_ovf_i,
  input  logic             evt_req_i,
  input  logic [STS_W-1:0] evt_prev_sts_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             irq_o,
  output logic [REG_W-1:0] msg_addr_o,
  output logic [REG_W-1:0] msg_data_o
);
  reg_sel_e         sel;
  logic             wr_sts, wr_ctl, wr_data, wr_addr;
  logic [STS_W-1:0] sts;
  logic             sts_clear, mask, ip;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign wr_sts  = reg_wr_i && (sel == SEL_STS);
  assign wr_ctl  = reg_wr_i && (sel == SEL_CTL);
  assign wr_data = reg_wr_i && (sel == SEL_DATA);
  assign wr_addr = reg_wr_i && (sel == SEL_ADDR);

  prq_status_reg u_sts (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (wr_sts),
    .w1c_i          (reg_wdata_i[STS_W-1:0]),
    .set_pend_i     (set_pend_i),
    .set_ovf_i      (set_ovf_i),
    .sts_o          (sts),
    .wr_all_clear_o (sts_clear)
  );

  prq_event_ctl u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_wr_i     (wr_ctl),
    .mask_wdata_i (reg_wdata_i[CTL_MASK_BIT]),
    .sts_clear_i  (sts_clear),
    .evt_req_i    (evt_req_i),
    .evt_prev_i   (evt_prev_sts_i),
    .mask_o       (mask),
    .ip_o         (ip),
    .irq_o        (irq_o)
  );

  prq_msg_regs #(
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .ADDR_LSB (ADDR_LSB)
  ) u_msg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_wr_i (wr_data),
    .addr_wr_i (wr_addr),
    .wdata_i   (reg_wdata_i),
    .data_o    (msg_data_o),
    .addr_o    (msg_addr_o)
  );

  always_comb begin
    status_o = '0;
    status_o[STS_W-1:0] = sts;
    ctrl_o = '0;
    ctrl_o[CTL_MASK_BIT] = mask;
    ctrl_o[CTL_IP_BIT]   = ip;
  end

  a_r8_clear_drops_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && ((sts & ~reg_wdata_i[STS_W-1:0]) == '0) && !set_pend_i
     && !set_ovf_i && !evt_req_i) |=> !ctrl_o[CTL_IP_BIT]);
  a_r10_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> (msg_addr_o[REG_W-1:ADDR_LSB] == $past(reg_wdata_i[REG_W-1:ADDR_LSB])));
endmodule

// File: tb/prq_notify_test.sv
`timescale 1ns/1ps
module prq_notify_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        set_pend = 1'b0, set_ovf = 1'b0, evt_req = 1'b0;
  logic [1:0]  evt_prev = 2'd0;
  logic [31:0] status, ctrl, maddr, mdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic [1:0]  m_sts;
  logic        m_mask, m_ip, m_irq;
  logic [31:0] m_data, m_addr;

  always #10 clk = ~clk;

  prq_notify uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .set_pend_i(set_pend), .set_ovf_i(set_ovf),
    .evt_req_i(evt_req), .evt_prev_sts_i(evt_prev), .status_o(status),
    .ctrl_o(ctrl), .irq_o(irq), .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    return {m_mask, m_ip, 30'd0};
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "status", status, {30'd0, m_sts});
    check(tag, "ctrl", ctrl, exp_ctrl());
    check(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    check(tag, "data", mdata, m_data);
    check(tag, "addr", maddr, m_addr);
  endtask

  // advance model by one edge from the current driven inputs
  task automatic model_step();
    logic [1:0] clr, nsts;
    logic acc, ipm, unm;
    clr  = (reg_wr && reg_sel == 2'd0) ? reg_wdata[1:0] : 2'b00;
    nsts = (m_sts & ~clr) | {set_ovf, set_pend};
    acc  = evt_req && (evt_prev == 2'b00);
    ipm  = (reg_wr && reg_sel == 2'd0 && nsts == 2'b00) ? 1'b0 : m_ip;
    if (acc && m_mask) ipm = 1'b1;
    unm  = reg_wr && reg_sel == 2'd1 && !reg_wdata[31] && ipm;
    m_irq = (acc && !m_mask) || unm;
    m_ip  = unm ? 1'b0 : ipm;
    if (reg_wr && reg_sel == 2'd1) m_mask = reg_wdata[31];
    if (reg_wr && reg_sel == 2'd2) m_data = {16'd0, reg_wdata[15:0]};
    if (reg_wr && reg_sel == 2'd3) m_addr = {reg_wdata[31:2], 2'b00};
    m_sts = nsts;
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    reg_wr = 1'b0; set_pend = 1'b0; set_ovf = 1'b0; evt_req = 1'b0;
    evt_prev = 2'd0; reg_wdata = '0; reg_sel = 2'd0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
  endtask

  task automatic evt(input logic [1:0] p);
    evt_req = 1'b1; evt_prev = p;
  endtask

  initial begin
    m_sts = 2'b00; m_mask = 1'b1; m_ip = 1'b0; m_irq = 1'b0;
    m_data = '0; m_addr = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    wr(2'd2, 32'hABCD_1234);                 cycle("R10");
    wr(2'd3, 32'hFFFF_FFFF);                 cycle("R10");
    wr(2'd1, 32'hFFFF_FFFF);                 cycle("R9");   // bit 30 ignored
    wr(2'd1, 32'h4000_0000);                 cycle("R9");   // unmask, ip stays 0
    set_pend = 1'b1;                         cycle("R2");
    set_ovf  = 1'b1;                         cycle("R2");
    wr(2'd0, 32'h0000_0002);                 cycle("R2");   // clear overflow only
    wr(2'd0, 32'h0000_0001);                 cycle("R2");
    wr(2'd0, 32'h0000_0003); set_pend = 1'b1; cycle("R3");
    evt(2'b01);                              cycle("R4");
    evt(2'b10);                              cycle("R4");
    evt(2'b11);                              cycle("R4");
    evt(2'b00);                              cycle("R5");
    check("R10", "irq addr", maddr, 32'hFFFF_FFFC);
    check("R10", "irq data", mdata, 32'h0000_1234);
                                             cycle("R5");   // pulse ends
    wr(2'd1, 32'h8000_0000);                 cycle("R6");
    evt(2'b00);                              cycle("R6");
    check("R6", "ip set", {31'd0, ctrl[30]}, 32'd1);
    evt(2'b01);                              cycle("R4");   // ip unchanged
    wr(2'd0, 32'h0000_0000);                 cycle("R8");   // status still nonzero
    wr(2'd1, 32'h0000_0000);                 cycle("R7");
    check("R7", "irq", {31'd0, irq}, 32'd1);
                                             cycle("R7");
    wr(2'd1, 32'h8000_0000);                 cycle("R6");
    evt(2'b00);                              cycle("R6");
    wr(2'd0, 32'h0000_0003);                 cycle("R8");   // both clear -> ip dropped
    check("R8", "ip cleared", {31'd0, ctrl[30]}, 32'd0);
    wr(2'd1, 32'h0000_0000);                 cycle("R8");   // no replay
    check("R8", "no irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 25) wr(2'($urandom_range(3)), $urandom());
      set_pend = ($urandom_range(99) < 10);
      set_ovf  = ($urandom_range(99) < 5);
      if ($urandom_range(99) < 20)
        evt(($urandom_range(1) == 0) ? 2'b00 : 2'($urandom_range(3)));
      cycle("R5");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule